// File: doc/BRIEF.md
# Configurable Latin-square check-bit encoder

This block takes one data word of M*M bits and computes every check bit of a single-step-decodable Latin-square code. Each check bit is the parity of one row of the parity-check matrix. It then keeps only the rows that a per-row keep vector selects, and packs those bits into a shorter field for storage next to the data. The keep vector is worked out after manufacture from the positions of weak cells, at test time or at boot. Every row of the full code is always available, and each chip stores only the check bits it needs.

The rows fall into 2T groups of M rows. Think of data bit index `b = i*M + j` as cell (i, j) of an M x M grid. Group 0 uses the row number i. Group 1 uses the column number j. A group g of 2 or more uses `(i + (g-1)*j) mod M`. Check bit index `g*M + r` is row r of group g. Packing keeps the kept rows in ascending index order, starting at stored bit 0, and drives every upper stored position to zero. The result is registered, so it appears one cycle after the word is accepted, together with a valid flag. The keep vector is sampled with each accepted word. Software changes it only while no word is offered.

Top module: `ols_cfg_encoder`

## Requirements
- R1: Full check bit `g*M + r` (default M=5, T=2: 25 data bits, 20 check bits) is the XOR of the data bits `d[i*M+j]` whose group-g row is r. Group 0 uses i, group 1 uses j, and group g of 2 or more uses `(i+(g-1)*j) mod M`. A one-hot data word therefore sets exactly 2T full check bits.
- R2: Kept check bits are packed in ascending row-index order. The lowest kept row goes to stored bit 0, the next to bit 1, and so on.
- R3: Stored positions at or above the number of kept rows are zero.
- R4: With every keep bit set, the stored field equals the full check vector. With no keep bit set, it is all zero.
- R5: `out_valid` is high in the cycle after a cycle in which `in_valid` is high. In that cycle `out_chk` holds the packed bits of the word accepted at that edge.
- R6: In a cycle after one with `in_valid` low, `out_valid` is low and `out_chk` keeps its previous value, whatever `in_data` does.
- R7: During reset and after it, until the first word, `out_valid` and `out_chk` are zero.
- R8: A change of `cfg_keep` while idle leaves `out_chk` unchanged. It takes effect on the next accepted word.
- R9: Within the full check vector, the XOR of each group's M bits equals the parity of the whole data word, because each data bit lies in exactly one row of every group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A data word is offered this cycle |
| in_data | input | M*M | Data word, bit i*M+j is grid cell (i, j) |
| cfg_keep | input | 2*T*M | Keep bit for each check row; 1 keeps it |
| out_valid | output | 1 | Stored field belongs to the word accepted last cycle |
| out_chk | output | 2*T*M | Packed check-bit field, upper positions zero |

## Verification
The checker assumes that `cfg_keep` holds still across consecutive cycles in which `in_valid` is high. It does not require that the vector be set before reset ends, because the vector is sampled only with accepted words. The bench changes the keep vector only in idle cycles, or in the first cycle of a burst, and holds it steady through every back-to-back stream. Idle cycles carry data that changes freely, so the hold property is exercised against a moving input rather than a frozen one.

// File: rtl/ols_enc_pkg.sv
package ols_enc_pkg;

  // Row of group g that holds grid cell (i, j) of an m x m grid.
  function automatic int ols_row_of(int g, int i, int j, int m);
    if (g == 0) return i;
    if (g == 1) return j;
    return (i + (g - 1) * j) % m;
  endfunction

  // True when data bit b is a member of check row c.
  function automatic bit ols_hit(int c, int b, int m);
    int g;
    int r;
    g = c / m;
    r = c % m;
    return ols_row_of(g, b / m, b % m, m) == r;
  endfunction

  // Bits needed to count from 0 to n inclusive.
  function automatic int ols_cnt_w(int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/ols_check_gen.sv
module ols_check_gen #(
  parameter int M = 5,
  parameter int T = 2
) (
  input  logic [M*M-1:0]   data,
  output logic [2*T*M-1:0] chk
);
  import ols_enc_pkg::*;

  localparam int DW = M * M;
  localparam int CW = 2 * T * M;

  // Membership mask of one parity-check row.
  function automatic logic [DW-1:0] row_mask(int c);
    logic [DW-1:0] msk;
    msk = '0;
    for (int b = 0; b < DW; b++) msk[b] = ols_hit(c, b, M);
    return msk;
  endfunction

  for (genvar c = 0; c < CW; c++) begin : g_row
    localparam logic [DW-1:0] MASK = row_mask(c);
    assign chk[c] = ^(data & MASK);
  end

endmodule

// File: rtl/ols_compact.sv
module ols_compact #(
  parameter int CW = 20
) (
  input  logic [CW-1:0] full,
  input  logic [CW-1:0] keep,
  output logic [CW-1:0] packed_out,
  output logic [ols_enc_pkg::ols_cnt_w(CW)-1:0] kept_cnt
);
  import ols_enc_pkg::*;

  localparam int IW = ols_cnt_w(CW);

  // rank[r]: number of kept rows below r, i.e. the slot row r lands in.
  logic [IW-1:0] rank [CW+1];

  always_comb begin
    rank[0] = '0;
    for (int r = 0; r < CW; r++) rank[r+1] = rank[r] + IW'(keep[r]);
  end

  assign kept_cnt = rank[CW];

  // One selector per stored slot; only rows at or above k can reach slot k.
  for (genvar k = 0; k < CW; k++) begin : g_slot
    logic sel_bit;
    always_comb begin
      sel_bit = 1'b0;
      for (int r = k; r < CW; r++) begin
        if (keep[r] && rank[r] == IW'(k)) sel_bit = full[r];
      end
    end
    assign packed_out[k] = sel_bit;
  end

endmodule

// File: rtl/ols_out_reg.sv
module ols_out_reg #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] d,
  output logic          q_valid,
  output logic [CW-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end

endmodule

// File: rtl/ols_cfg_encoder.sv
module ols_cfg_encoder #(
  parameter int M = 5,
  parameter int T = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [M*M-1:0]   in_data,
  input  logic [2*T*M-1:0] cfg_keep,
  output logic             out_valid,
  output logic [2*T*M-1:0] out_chk
);
  import ols_enc_pkg::*;

  localparam int DW = M * M;
  localparam int CW = 2 * T * M;
  localparam int IW = ols_cnt_w(CW);

  // Named internal events for the checker.
  logic          word_accept;
  logic [CW-1:0] full_chk;
  logic [CW-1:0] packed_chk;
  logic [IW-1:0] kept_cnt;

  assign word_accept = in_valid;

  ols_check_gen #(.M(M), .T(T)) gen_i (
    .data (in_data),
    .chk  (full_chk)
  );

  ols_compact #(.CW(CW)) pack_i (
    .full       (full_chk),
    .keep       (cfg_keep),
    .packed_out (packed_chk),
    .kept_cnt   (kept_cnt)
  );

  ols_out_reg #(.CW(CW)) oreg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (word_accept),
    .d       (packed_chk),
    .q_valid (out_valid),
    .q       (out_chk)
  );

  logic unused_ok;
  assign unused_ok = ^kept_cnt | (DW == 0);

endmodule

// File: rtl/ols_cfg_encoder_chk.sv
module ols_cfg_encoder_chk #(
  parameter int M = 5,
  parameter int T = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [M*M-1:0]   in_data,
  input logic [2*T*M-1:0] cfg_keep,
  input logic             out_valid,
  input logic [2*T*M-1:0] out_chk,
  input logic [2*T*M-1:0] full_chk
);

  // Input rule: keep vector steady inside a burst
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $past(in_valid)) |-> $stable(cfg_keep));

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_chk)));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_chk >> $past($countones(cfg_keep))) == '0));

  // R4
  all_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&cfg_keep)) |=> (out_chk == $past(full_chk)));

  // R4
  none_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_keep == '0) |=> (out_chk == '0));

  // R1
  one_hot_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $countones(in_data) == 1 && (&cfg_keep))
      |=> ($countones(out_chk) == 2 * T));

  // R9
  for (genvar g = 1; g < 2 * T; g++) begin : g_par
    group_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ((^full_chk[g*M +: M]) == (^in_data)));
  end

endmodule

bind ols_cfg_encoder ols_cfg_encoder_chk #(.M(M), .T(T)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .cfg_keep  (cfg_keep),
  .out_valid (out_valid),
  .out_chk   (out_chk),
  .full_chk  (full_chk)
);

// File: tb/ols_cfg_encoder_tb.sv
module ols_cfg_encoder_tb_top;

  localparam int M  = 5;
  localparam int T  = 2;
  localparam int DW = M * M;
  localparam int CW = 2 * T * M;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] cfg_keep = '0;
  logic          out_valid;
  logic [CW-1:0] out_chk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ols_cfg_encoder #(.M(M), .T(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_keep(cfg_keep), .out_valid(out_valid), .out_chk(out_chk)
  );

  // Reference: membership tested as (r - i) == slope*j modulo M.
  function automatic logic [CW-1:0] ref_full(logic [DW-1:0] d);
    logic [CW-1:0] v;
    v = '0;
    for (int c = 0; c < CW; c++) begin
      int g;
      int r;
      g = c / M;
      r = c % M;
      for (int i = 0; i < M; i++) begin
        for (int j = 0; j < M; j++) begin
          bit mem;
          if (g == 0)      mem = (i == r);
          else if (g == 1) mem = (j == r);
          else             mem = (((r - i + M * M) % M) == (((g - 1) * j) % M));
          if (mem) v[c] = v[c] ^ d[i*M+j];
        end
      end
    end
    return v;
  endfunction

  function automatic logic [CW-1:0] ref_pack(logic [CW-1:0] f, logic [CW-1:0] k);
    logic [CW-1:0] o;
    int p;
    o = '0;
    p = 0;
    for (int c = 0; c < CW; c++) if (k[c]) begin o[p] = f[c]; p++; end
    return o;
  endfunction

  task automatic check(string req, logic [CW-1:0] got, logic [CW-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Offer one word, then sample at the following falling edge.
  task automatic send(logic [DW-1:0] d, logic [CW-1:0] k);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; cfg_keep = k;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 valid", CW'(out_valid), CW'(1));
    check("R1/R2 packed", out_chk, ref_pack(ref_full(d), k));
  endtask

  task automatic t_reset();
    in_data = '1; cfg_keep = '1;
    repeat (3) @(negedge clk);
    check("R7 valid in reset", CW'(out_valid), '0);
    check("R7 chk in reset", out_chk, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 valid after reset", CW'(out_valid), '0);
    check("R7 chk after reset", out_chk, '0);
  endtask

  task automatic t_one_hot();
    for (int b = 0; b < DW; b++) begin
      logic [DW-1:0] d;
      d = '0; d[b] = 1'b1;
      send(d, '1);
      check("R1 one-hot weight", CW'($countones(out_chk)), CW'(2 * T));
      check("R4 all kept", out_chk, ref_full(d));
    end
  endtask

  task automatic t_patterns();
    logic [DW-1:0] d;
    d = 25'h1A5C3E7;
    for (int n = 0; n < 12; n++) begin
      d = DW'(d * 1103515245 + 12345 + n);
      send(d, '1);
      for (int g = 0; g < 2 * T; g++)
        check("R9 group parity", CW'(^out_chk[g*M +: M]), CW'(^d));
      send(d, '0);
      check("R4 none kept", out_chk, '0);
    end
  endtask

  task automatic t_sparse();
    logic [CW-1:0] kl [6];
    logic [DW-1:0] d;
    kl[0] = 20'h00001; kl[1] = 20'h80000; kl[2] = 20'hAAAAA;
    kl[3] = 20'h5555F; kl[4] = 20'hF0000; kl[5] = 20'h0F0F1;
    d = 25'h0BEEF42;
    for (int n = 0; n < 6; n++) begin
      for (int v = 0; v < 4; v++) begin
        d = DW'(d * 69069 + 1);
        send(d, kl[n]);
        check("R3 upper zero", out_chk >> $countones(kl[n]), '0);
      end
    end
    // Only the top row kept: it must land in bit 0 (R2)
    d = 25'h1FFFFFF;
    send(d, 20'h80000);
    check("R2 top row to bit0", out_chk, CW'(ref_full(d)[CW-1]));
  endtask

  task automatic t_hold();
    logic [CW-1:0] held;
    send(25'h1234567, 20'h3C3C3);
    held = out_chk;
    for (int n = 0; n < 5; n++) begin
      in_data = DW'(n * 7919 + 3);
      @(negedge clk);
      check("R6 valid low", CW'(out_valid), '0);
      check("R6 chk held", out_chk, held);
    end
  endtask

  task automatic t_cfg_idle();
    logic [CW-1:0] held;
    send(25'h0ACE135, 20'h0000F);
    held = out_chk;
    cfg_keep = 20'hFFFF0;
    repeat (2) @(negedge clk);
    check("R8 idle change no effect", out_chk, held);
    send(25'h0ACE135, 20'hFFFF0);
    check("R8 new keep used", out_chk, ref_pack(ref_full(25'h0ACE135), 20'hFFFF0));
  endtask

  task automatic t_stream();
    logic [DW-1:0] d;
    logic [CW-1:0] k;
    logic [CW-1:0] prev;
    k = 20'h6B3D9;
    d = 25'h0F00F0F;
    @(negedge clk);
    cfg_keep = k;
    in_valid = 1'b1;
    in_data = d;
    prev = ref_pack(ref_full(d), k);
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      check("R5 stream valid", CW'(out_valid), CW'(1));
      check("R5 stream data", out_chk, prev);
      d = DW'(d * 1664525 + 1013904223);
      in_data = d;
      prev = ref_pack(ref_full(d), k);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 stream last", out_chk, prev);
  endtask

  initial begin
    t_reset();
    t_one_hot();
    t_patterns();
    t_sparse();
    t_hold();
    t_cfg_idle();
    t_stream();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule